// File: doc/BRIEF.md
# Direct-Mapped Load Cache

This block is a small direct-mapped read cache placed between a load unit and a byte-addressable, little-endian backing memory. Each line holds a valid bit, a tag and one 32-bit word. A request carries a byte address and a load kind: a full-word load or an unsigned byte load. The address is split, from most to least significant, into a tag, an index that selects a line, and a 2-bit byte offset. The tag width is the address width minus the index width minus 2.

A request whose indexed line is valid and whose stored tag matches is a hit, and it is answered one cycle later. Any other request is a miss. The cache reads the word-aligned word from memory, installs it in the indexed line, replacing whatever the line held, and then answers. While a fill is outstanding the cache does not accept requests. A word load with a nonzero offset is reported as misaligned and does not touch the lines. Address width and line count are parameters; the default is an 8-bit address with 4 lines, which gives a 4-bit tag and a 2-bit index.

Top module: `dm_load_cache`

## Requirements
- R1: A synchronous reset clears every valid bit. During and after reset `req_ready`=1, `rsp_valid`=0 and `mem_rd`=0, and the first access to each index is a miss.
- R2: A request is a hit only when the indexed line is valid and its stored tag equals address bits [ADDR_W-1:IDX_W+2]. The index is bits [IDX_W+1:2]. A hit gives `rsp_valid`=1 with `rsp_hit`=1 one cycle after acceptance, and it issues no memory read.
- R3: On a miss, `mem_rd` rises one cycle after acceptance. `mem_addr` is the request address with bits [1:0] forced to 0. Both are held until a cycle with `mem_valid`=1.
- R4: A miss response appears one cycle after the cycle in which `mem_valid` was high while `mem_rd` was high. It has `rsp_hit`=0, and its data is selected from `mem_data`. The fetched word, with its tag and a set valid bit, replaces the indexed line.
- R5: A word load (`req_op`=0) returns the whole 32-bit line word.
- R6: A byte load (`req_op`=1) returns bits [8*o+7:8*o] of the word, where o is the byte offset, zero-extended to 32 bits. Offset 0 is the least significant byte.
- R7: A word load with a nonzero offset responds one cycle after acceptance with `rsp_misalign`=1, `rsp_hit`=0 and `rsp_data`=0. It issues no memory read and leaves every line unchanged.
- R8: While a miss is outstanding, `req_ready`=0 and requests offered on the port are ignored: they cause no response and no line change.
- R9: Two addresses with the same index and different tags evict each other, so alternating between them misses every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load request offered |
| req_op | input | 1 | 0 = word load, 1 = unsigned byte load |
| req_addr | input | ADDR_W | Byte address of the load |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse marking a response |
| rsp_hit | output | 1 | Response was served from a line |
| rsp_misalign | output | 1 | Word load with a nonzero offset was rejected |
| rsp_data | output | 32 | Loaded value |
| mem_rd | output | 1 | Memory read request, held until served |
| mem_addr | output | ADDR_W | Word-aligned memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_data | input | 32 | Memory read data |

## Verification
Hit and misaligned responses are due exactly one cycle after the accepting edge. The bench drives a request on a falling edge and looks for the response on the very next falling edge; in that same sample it checks that no memory read was raised. A miss response is due one cycle after the memory model's data-valid cycle. The memory model records the cycle in which it answered, and the bench checks that the response arrives at that cycle plus one. Memory latency varies from zero to three cycles, and the bench checks on every waiting sample that `req_ready` stays low and the read address stays aligned.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic {
        OP_WORD = 1'b0,
        OP_BYTE = 1'b1
    } load_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } cache_st_e;

    localparam int WORD_W = 32;
    localparam int OFF_W  = 2;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - dmc_pkg::OFF_W
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic [TAG_W-1:0]         tag,
    output logic [IDX_W-1:0]         idx,
    output logic [dmc_pkg::OFF_W-1:0] off
);
    always_comb begin
        off = addr[dmc_pkg::OFF_W-1:0];
        idx = addr[dmc_pkg::OFF_W +: IDX_W];
        tag = addr[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int LINES = 4,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic                        rd_valid,
    output logic [TAG_W-1:0]            rd_tag,
    output logic [dmc_pkg::WORD_W-1:0]  rd_data,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [dmc_pkg::WORD_W-1:0]  wr_data
);
    logic [LINES-1:0]                 valid_q;
    logic [TAG_W-1:0]                 tag_q  [LINES];
    logic [dmc_pkg::WORD_W-1:0]       data_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic                       sel;
        logic                       valid_d;
        logic [TAG_W-1:0]           tag_d;
        logic [dmc_pkg::WORD_W-1:0] data_d;

        always_comb begin
            sel     = wr_en && (wr_idx == IDX_W'(i));
            valid_d = valid_q[i];
            tag_d   = tag_q[i];
            data_d  = data_q[i];
            if (sel) begin
                valid_d = 1'b1;
                tag_d   = wr_tag;
                data_d  = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
            end else begin
                valid_q[i] <= valid_d;
            end
            tag_q[i]  <= tag_d;
            data_q[i] <= data_d;
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end
endmodule

// File: rtl/dmc_byte_pick.sv
module dmc_byte_pick (
    input  logic [dmc_pkg::WORD_W-1:0] word,
    input  logic [dmc_pkg::OFF_W-1:0]  off,
    input  logic                       op,
    output logic [dmc_pkg::WORD_W-1:0] result
);
    import dmc_pkg::*;

    logic [7:0] lane;

    always_comb begin
        case (off)
            2'd0:    lane = word[7:0];
            2'd1:    lane = word[15:8];
            2'd2:    lane = word[23:16];
            default: lane = word[31:24];
        endcase
        if (op == OP_BYTE) begin
            result = {24'h0, lane};
        end else begin
            result = word;
        end
    end
endmodule

// File: rtl/dm_load_cache.sv
module dm_load_cache #(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_misalign,
    output logic [31:0]       rsp_data,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [31:0]       mem_data
);
    import dmc_pkg::*;

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        cache_st_e           state;
        logic                mem_rd;
        logic [ADDR_W-1:0]   mem_addr;
        logic                pend_op;
        logic [OFF_W-1:0]    pend_off;
        logic [IDX_W-1:0]    pend_idx;
        logic [TAG_W-1:0]    pend_tag;
        logic                rsp_valid;
        logic                rsp_hit;
        logic                rsp_mis;
        logic [WORD_W-1:0]   rsp_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [WORD_W-1:0] line_data;
    logic [WORD_W-1:0] hit_result;
    logic [WORD_W-1:0] fill_result;
    logic              fill_we;
    logic              lookup_hit;
    logic              misaligned;

    dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split (
        .addr (req_addr),
        .tag  (req_tag),
        .idx  (req_idx),
        .off  (req_off)
    );

    dmc_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (line_data),
        .wr_en    (fill_we),
        .wr_idx   (ctl_q.pend_idx),
        .wr_tag   (ctl_q.pend_tag),
        .wr_data  (mem_data)
    );

    dmc_byte_pick u_pick_hit (
        .word   (line_data),
        .off    (req_off),
        .op     (req_op),
        .result (hit_result)
    );

    dmc_byte_pick u_pick_fill (
        .word   (mem_data),
        .off    (ctl_q.pend_off),
        .op     (ctl_q.pend_op),
        .result (fill_result)
    );

    always_comb begin
        lookup_hit = line_valid && (line_tag == req_tag);
        misaligned = (req_op == OP_WORD) && (req_off != '0);
        req_ready  = (ctl_q.state == ST_IDLE);
        fill_we    = 1'b0;

        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.rsp_hit   = 1'b0;
        ctl_d.rsp_mis   = 1'b0;
        ctl_d.rsp_data  = '0;

        case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (misaligned) begin
                        ctl_d.rsp_valid = 1'b1;
                        ctl_d.rsp_mis   = 1'b1;
                    end else if (lookup_hit) begin
                        ctl_d.rsp_valid = 1'b1;
                        ctl_d.rsp_hit   = 1'b1;
                        ctl_d.rsp_data  = hit_result;
                    end else begin
                        ctl_d.state    = ST_FILL;
                        ctl_d.mem_rd   = 1'b1;
                        ctl_d.mem_addr = {req_tag, req_idx, {OFF_W{1'b0}}};
                        ctl_d.pend_op  = req_op;
                        ctl_d.pend_off = req_off;
                        ctl_d.pend_idx = req_idx;
                        ctl_d.pend_tag = req_tag;
                    end
                end
            end
            ST_FILL: begin
                if (mem_valid) begin
                    fill_we         = 1'b1;
                    ctl_d.state     = ST_IDLE;
                    ctl_d.mem_rd    = 1'b0;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = fill_result;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid    = ctl_q.rsp_valid;
    assign rsp_hit      = ctl_q.rsp_hit;
    assign rsp_misalign = ctl_q.rsp_mis;
    assign rsp_data     = ctl_q.rsp_data;
    assign mem_rd       = ctl_q.mem_rd;
    assign mem_addr     = ctl_q.mem_addr;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_misalign,
    input logic [31:0]       rsp_data,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !mem_rd && req_ready));

    assert_hit_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_valid && !rsp_misalign));

    assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr[1:0] == 2'b00));

    assert_fill_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_valid) |=> (mem_rd && $stable(mem_addr)));

    assert_miss_after_mem_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && !rsp_misalign) |-> ($past(mem_valid) && $past(mem_rd)));

    assert_misalign_clean_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_misalign |-> (rsp_valid && !rsp_hit && (rsp_data == 32'h0)));

    assert_fill_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (!req_ready && !rsp_valid));
endmodule

bind dm_load_cache dmc_checker #(.ADDR_W(ADDR_W)) u_dmc_checker (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_misalign (rsp_misalign),
    .rsp_data     (rsp_data),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .mem_valid    (mem_valid)
);

// File: tb/dm_load_cache_bench.sv
`timescale 1ns/1ps
module dm_load_cache_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [7:0]  req_addr = 8'h0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_misalign;
    logic [31:0] rsp_data;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = 32'h0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int mv_cyc = -10;
    int lat = 0;
    bit mvld [4];
    int mtag [4];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dm_load_cache u_dm_load_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_misalign(rsp_misalign), .rsp_data(rsp_data),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_data(mem_data)
    );

    function automatic logic [7:0] mb(input int b);
        return 8'((b * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] mword(input int aw);
        return {mb(aw + 3), mb(aw + 2), mb(aw + 1), mb(aw)};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // memory model: answers after lat waiting samples
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd && !mem_valid) begin
                if (cnt >= lat) begin
                    mem_valid = 1'b1;
                    mem_data  = mword(int'(mem_addr));
                    mv_cyc    = cyc;
                    cnt       = 0;
                end else begin
                    cnt++;
                end
            end else begin
                mem_valid = 1'b0;
            end
        end
    end

    task automatic do_load(input logic op, input int a, input bit hold, input string rq);
        logic [7:0]  ad;
        int          idx;
        int          tg;
        bit          mis;
        bit          hit;
        logic [31:0] ed;
        int          waitc;
        ad  = a[7:0];
        idx = (a >> 2) & 3;
        tg  = (a >> 4) & 15;
        mis = (op == 1'b0) && ((a % 4) != 0);
        hit = !mis && mvld[idx] && (mtag[idx] == tg);
        if (mis) ed = 32'h0;
        else if (op) ed = {24'h0, mb(a)};
        else ed = mword(a & ~3);
        lat = (a / 4) % 4;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = ad;
        @(negedge clk);
        req_valid = 1'b0;
        if (mis || hit) begin
            chk({rq, " R2/R7 response one cycle after accept"}, 32'(rsp_valid), 32'd1);
            chk({rq, " R2/R7 no memory read"}, 32'(mem_rd), 32'd0);
        end else begin
            if (hold) begin
                req_valid = 1'b1;
                req_op    = 1'b1;
                req_addr  = ad ^ 8'h04;
            end
            chk({rq, " R3 read raised"}, 32'(mem_rd), 32'd1);
            chk({rq, " R3 aligned read address"}, 32'(mem_addr), 32'({ad[7:2], 2'b00}));
            chk({rq, " R8 ready low in fill"}, 32'(req_ready), 32'd0);
            waitc = 0;
            while (!rsp_valid && waitc < 50) begin
                @(negedge clk);
                waitc++;
                if (!rsp_valid) chk({rq, " R8 ready low while waiting"}, 32'(req_ready), 32'd0);
            end
            req_valid = 1'b0;
            chk({rq, " R4 response one cycle after memory data"}, 32'(cyc), 32'(mv_cyc + 1));
            mvld[idx] = 1'b1;
            mtag[idx] = tg;
        end
        chk({rq, " R2 hit flag"}, 32'(rsp_hit), 32'(hit));
        chk({rq, " R7 misalign flag"}, 32'(rsp_misalign), 32'(mis));
        chk({rq, " R5/R6 data"}, rsp_data, ed);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mvld[i] = 1'b0; mtag[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 no response in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 no read after reset", 32'(mem_rd), 32'd0);
        chk("R1 no response after reset", 32'(rsp_valid), 32'd0);

        // R1: first touch of every index misses
        for (int i = 0; i < 4; i++) do_load(1'b1, i * 4 + 1, 1'b0, "R1 first access");

        // R6 R2 R4: byte loads over the full address space
        for (int a = 0; a < 256; a++) do_load(1'b1, a, 1'b0, "R6 byte sweep");
        for (int a = 255; a >= 0; a -= 3) do_load(1'b1, a, 1'b0, "R6 reverse sweep");

        // R5 R4: word loads, repeated to hit the installed line
        for (int a = 0; a < 256; a += 4) begin
            do_load(1'b0, a, 1'b0, "R5 word load");
            do_load(1'b0, a, 1'b0, "R4 installed line");
        end

        // R7: misaligned word loads leave lines unchanged
        for (int a = 0; a < 256; a++) begin
            if ((a % 4) != 0) begin
                do_load(1'b0, a, 1'b0, "R7 misaligned");
                do_load(1'b1, a, 1'b0, "R7 line unchanged");
            end
        end

        // R9: same index, different tags
        for (int k = 0; k < 6; k++) do_load(1'b1, (k % 2) ? 8'h92 : 8'h12, 1'b0, "R9 conflict");

        // R8: requests offered while a fill is outstanding are ignored
        do_load(1'b1, 8'h20, 1'b0, "R8 prime");
        do_load(1'b1, 8'h34, 1'b0, "R8 prime");
        do_load(1'b1, 8'h60, 1'b1, "R8 held request");
        @(negedge clk);
        chk("R8 no response for ignored request", 32'(rsp_valid), 32'd0);
        chk("R8 no read for ignored request", 32'(mem_rd), 32'd0);
        do_load(1'b1, 8'h34, 1'b0, "R8 neighbour line intact");
        do_load(1'b1, 8'h64, 1'b0, "R8 ignored address not installed");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule